// File: doc/BRIEF.md
# Sort-Then-Self-Route Switch Network

This block moves one time slot of fixed-size cells across an eight-port fabric. Every input lane offers a valid flag, a 3-bit destination port number and a payload word. The cells are first ordered by destination in a compare-exchange sorting network, with empty lanes pushed to the end. Repeated requests for one destination are then trapped. The cells that remain are packed into a gap-free run starting at lane 0, and a perfect-shuffle permutation is applied to them. A three-stage network of 2x2 self-routing elements then steers each cell to its port. Each element looks at one destination bit: a 0 sends the cell to the upper output and a 1 sends it to the lower output.

The fabric is combinational and sits between a register on the inputs and a register on the outputs. A new slot can be offered on every clock. The block reports a per-port valid and payload, a per-input dropped flag for cells that lost to a duplicate, and a conflict flag that rises if two cells ever meet at one 2x2 element and want the same output.

Top module: `sort_route_switch`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid`, `out_payload`, `dropped` and `conflict` are all zero.
- R2: A slot present on the inputs at clock edge k appears on the outputs after edge k+1. Slots offered on consecutive cycles come out on consecutive cycles without loss.
- R3: For each slot, `out_valid[d]` is 1 exactly when at least one valid input requested destination d. All other ports show valid 0 and payload 0.
- R4: When several valid inputs request the same destination, the cell from the lowest-numbered input is delivered, and that port carries that input's payload unchanged.
- R5: `dropped[i]` is 1 exactly when input i was valid and a lower-numbered valid input requested the same destination. An input that is not valid never shows dropped.
- R6: The destination and payload of an input whose `in_valid` bit is 0 have no effect on any output.
- R7: For every combination of valid bits and destinations, no two cells ever contend for one output of a 2x2 element, so `conflict` stays 0.
- R8: Lane i uses `in_valid[i]`, `in_dest[3*i +: 3]` and `in_payload[PAYLOAD_W*i +: PAYLOAD_W]`. A destination value d, read as an unsigned binary number from 0 to 7, selects output port d, which is `out_valid[d]` and `out_payload[PAYLOAD_W*d +: PAYLOAD_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N_PORTS | Per-lane cell present flag |
| in_dest | input | N_PORTS*3 | Per-lane destination port number |
| in_payload | input | N_PORTS*PAYLOAD_W | Per-lane cell payload |
| out_valid | output | N_PORTS | Per-port cell delivered flag |
| out_payload | output | N_PORTS*PAYLOAD_W | Per-port delivered payload |
| dropped | output | N_PORTS | Per-lane flag: cell lost to a lower-numbered duplicate |
| conflict | output | 1 | Two cells met at one self-routing element and wanted the same output |

## Verification
The bench uses directed patterns first. A full identity permutation and a full reversed permutation show that port numbering and bit steering are right on every lane. The slot with gaps and a pair of duplicates shows trapping and compaction. Eight cells aimed at one port single out the lowest-index winner and seven dropped flags. Random slots with valid densities from sparse to full and many repeated destinations then expose ordering faults in the sorter and shuffle wiring, which would show up as misdelivered payloads or a raised conflict flag. Back-to-back streaming shows that slots stay apart.

// File: rtl/srs_pkg.sv
package srs_pkg;

  // Perfect shuffle: rotate a lane index of `bits` bits left by one.
  function automatic int unsigned shuffle_pos(int unsigned p, int unsigned bits);
    int unsigned mask;
    mask = (32'd1 << bits) - 32'd1;
    return ((p << 1) | (p >> (bits - 1))) & mask;
  endfunction

endpackage

// File: rtl/srs_sorter.sv
module srs_sorter #(
  parameter int N_PORTS   = 8,
  parameter int ADDR_W    = 3,
  parameter int PAYLOAD_W = 8,
  localparam int CELL_W   = 1 + 2 * ADDR_W + PAYLOAD_W
) (
  input  logic [CELL_W-1:0] cells_i [N_PORTS],
  output logic [CELL_W-1:0] cells_o [N_PORTS]
);
  localparam int N_STAGES = ADDR_W * (ADDR_W + 1) / 2;
  localparam int KEY_W    = 1 + 2 * ADDR_W;

  // Order key: empty lanes last, then destination, then source lane.
  function automatic logic [KEY_W-1:0] key_of(logic [CELL_W-1:0] c);
    return {~c[CELL_W-1], c[CELL_W-2:PAYLOAD_W]};
  endfunction

  logic [CELL_W-1:0] stg [N_STAGES+1][N_PORTS];

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_io
    assign stg[0][gi] = cells_i[gi];
    assign cells_o[gi] = stg[N_STAGES][gi];
  end

  // Bitonic network: sort pairs, then merge blocks of doubling size.
  for (genvar gk = 1; gk <= ADDR_W; gk++) begin : g_blk
    for (genvar gm = 0; gm < gk; gm++) begin : g_pass
      localparam int GJ = gk - 1 - gm;
      localparam int ST = gk * (gk - 1) / 2 + gm;
      for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_lane
        if (((gi >> GJ) & 1) == 0) begin : g_cx
          localparam int PI  = gi | (1 << GJ);
          localparam bit ASC = ((gi >> gk) & 1) == 0;
          logic swap;
          if (ASC) begin : g_up
            assign swap = key_of(stg[ST][gi]) > key_of(stg[ST][PI]);
          end else begin : g_dn
            assign swap = key_of(stg[ST][gi]) < key_of(stg[ST][PI]);
          end
          assign stg[ST+1][gi] = swap ? stg[ST][PI] : stg[ST][gi];
          assign stg[ST+1][PI] = swap ? stg[ST][gi] : stg[ST][PI];
        end
      end
    end
  end

endmodule

// File: rtl/srs_trap_compact.sv
module srs_trap_compact
  import srs_pkg::*;
#(
  parameter int N_PORTS   = 8,
  parameter int ADDR_W    = 3,
  parameter int PAYLOAD_W = 8,
  localparam int CELL_W   = 1 + 2 * ADDR_W + PAYLOAD_W
) (
  input  logic [CELL_W-1:0] sorted_i [N_PORTS],
  output logic [CELL_W-1:0] shuf_o   [N_PORTS]
);
  localparam int VB = CELL_W - 1;

  logic [N_PORTS-1:0] keep;
  logic [CELL_W-1:0]  comp [N_PORTS];

  // Trap: a cell whose sorted neighbour above has the same destination loses.
  always_comb begin
    keep[0] = sorted_i[0][VB];
    for (int i = 1; i < N_PORTS; i++) begin
      keep[i] = sorted_i[i][VB] &&
                !(sorted_i[i-1][VB] &&
                  sorted_i[i-1][VB-1 -: ADDR_W] == sorted_i[i][VB-1 -: ADDR_W]);
    end
  end

  // Compaction: survivors packed into lanes 0.. in sorted order.
  always_comb begin
    logic [ADDR_W:0] r;
    for (int p = 0; p < N_PORTS; p++) comp[p] = '0;
    r = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (keep[i]) begin
        comp[r[ADDR_W-1:0]] = sorted_i[i];
        r = r + 1'b1;
      end
    end
  end

  for (genvar gp = 0; gp < N_PORTS; gp++) begin : g_shuf
    assign shuf_o[shuffle_pos(gp, ADDR_W)] = comp[gp];
  end

endmodule

// File: rtl/srs_banyan.sv
module srs_banyan
  import srs_pkg::*;
#(
  parameter int N_PORTS   = 8,
  parameter int ADDR_W    = 3,
  parameter int PAYLOAD_W = 8,
  localparam int CELL_W   = 1 + 2 * ADDR_W + PAYLOAD_W
) (
  input  logic [CELL_W-1:0] cells_i [N_PORTS],
  output logic [CELL_W-1:0] cells_o [N_PORTS],
  output logic              conflict_o
);
  localparam int HALF = N_PORTS / 2;
  localparam int VB   = CELL_W - 1;

  logic [CELL_W-1:0]        lvl [ADDR_W+1][N_PORTS];
  logic [ADDR_W*HALF-1:0]   clash;

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_io
    assign lvl[0][gi]  = cells_i[gi];
    assign cells_o[gi] = lvl[ADDR_W][gi];
  end

  for (genvar gs = 0; gs < ADDR_W; gs++) begin : g_stage
    localparam int DB = CELL_W - 2 - gs;  // destination bit, MSB first
    logic [CELL_W-1:0] pre [N_PORTS];

    // Inter-stage perfect shuffle (the first one is done ahead of this block).
    for (genvar gp = 0; gp < N_PORTS; gp++) begin : g_wire
      if (gs == 0) begin : g_direct
        assign pre[gp] = lvl[gs][gp];
      end else begin : g_shuf
        assign pre[shuffle_pos(gp, ADDR_W)] = lvl[gs][gp];
      end
    end

    for (genvar gm = 0; gm < HALF; gm++) begin : g_elem
      logic [CELL_W-1:0] up, lo;
      logic uv, lv, ub, lb;
      assign up = pre[2*gm];
      assign lo = pre[2*gm+1];
      assign uv = up[VB];
      assign lv = lo[VB];
      assign ub = up[DB];
      assign lb = lo[DB];
      // Bit 0 -> upper output, bit 1 -> lower output; upper input wins a clash.
      assign lvl[gs+1][2*gm]   = (uv && !ub) ? up : ((lv && !lb) ? lo : '0);
      assign lvl[gs+1][2*gm+1] = (uv &&  ub) ? up : ((lv &&  lb) ? lo : '0);
      assign clash[gs*HALF+gm] = uv && lv && (ub == lb);
    end
  end

  assign conflict_o = |clash;

endmodule

// File: rtl/sort_route_switch.sv
module sort_route_switch #(
  parameter int N_PORTS   = 8,
  parameter int PAYLOAD_W = 8,
  localparam int ADDR_W   = $clog2(N_PORTS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_PORTS-1:0]             in_valid,
  input  logic [N_PORTS*ADDR_W-1:0]      in_dest,
  input  logic [N_PORTS*PAYLOAD_W-1:0]   in_payload,
  output logic [N_PORTS-1:0]             out_valid,
  output logic [N_PORTS*PAYLOAD_W-1:0]   out_payload,
  output logic [N_PORTS-1:0]             dropped,
  output logic                           conflict
);
  localparam int CELL_W = 1 + 2 * ADDR_W + PAYLOAD_W;
  localparam int VB     = CELL_W - 1;

  logic [N_PORTS-1:0]           v_q;
  logic [N_PORTS*ADDR_W-1:0]    d_q;
  logic [N_PORTS*PAYLOAD_W-1:0] p_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      d_q <= '0;
      p_q <= '0;
    end else begin
      v_q <= in_valid;
      d_q <= in_dest;
      p_q <= in_payload;
    end
  end

  logic [CELL_W-1:0] cell_in [N_PORTS];
  logic [CELL_W-1:0] sorted  [N_PORTS];
  logic [CELL_W-1:0] shuf    [N_PORTS];
  logic [CELL_W-1:0] routed  [N_PORTS];
  logic              clash_n;

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_cell
    assign cell_in[gi] = {v_q[gi], d_q[gi*ADDR_W +: ADDR_W], ADDR_W'(gi),
                          p_q[gi*PAYLOAD_W +: PAYLOAD_W]};
  end

  srs_sorter #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W)) i_sorter (
    .cells_i (cell_in),
    .cells_o (sorted)
  );

  srs_trap_compact #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W)) i_trap (
    .sorted_i (sorted),
    .shuf_o   (shuf)
  );

  srs_banyan #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W)) i_banyan (
    .cells_i    (shuf),
    .cells_o    (routed),
    .conflict_o (clash_n)
  );

  logic [N_PORTS-1:0]           v_n;
  logic [N_PORTS*PAYLOAD_W-1:0] p_n;
  logic [N_PORTS-1:0]           hit;

  always_comb begin
    hit = '0;
    for (int d = 0; d < N_PORTS; d++) begin
      v_n[d] = routed[d][VB];
      p_n[d*PAYLOAD_W +: PAYLOAD_W] = routed[d][VB] ? routed[d][PAYLOAD_W-1:0] : '0;
      if (routed[d][VB]) hit[routed[d][PAYLOAD_W +: ADDR_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= '0;
      out_payload <= '0;
      dropped     <= '0;
      conflict    <= 1'b0;
    end else begin
      out_valid   <= v_n;
      out_payload <= p_n;
      dropped     <= v_q & ~hit;
      conflict    <= clash_n;
    end
  end

endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int N_PORTS = 8,
  parameter int ADDR_W  = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_PORTS-1:0]        in_valid,
  input logic [N_PORTS*ADDR_W-1:0] in_dest,
  input logic [N_PORTS-1:0]        out_valid,
  input logic [N_PORTS-1:0]        dropped,
  input logic                      conflict
);
  logic [N_PORTS-1:0] want;
  logic [N_PORTS-1:0] loser;

  always_comb begin
    want  = '0;
    loser = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (in_valid[i]) begin
        if (want[in_dest[i*ADDR_W +: ADDR_W]]) loser[i] = 1'b1;
        want[in_dest[i*ADDR_W +: ADDR_W]] = 1'b1;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (out_valid == '0 && dropped == '0 && !conflict));  // R1

  AST_DELIVER_SET: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(want, 2));  // R3

  AST_LOSER_FLAGS: assert property (@(posedge clk) disable iff (rst)
    dropped == $past(loser, 2));  // R5

  AST_DROP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (dropped & ~$past(in_valid, 2)) == '0);  // R6

  AST_NO_BLOCKING: assert property (@(posedge clk) disable iff (rst)
    !conflict);  // R7

endmodule

bind sort_route_switch srs_checker #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) i_srs_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_dest   (in_dest),
  .out_valid (out_valid),
  .dropped   (dropped),
  .conflict  (conflict)
);

// File: tb/test_sort_route_switch.sv
`timescale 1ns/1ps
module test_sort_route_switch;
  localparam int N = 8;
  localparam int A = 3;
  localparam int W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N-1:0]     in_valid = '0;
  logic [N*A-1:0]   in_dest = '0;
  logic [N*W-1:0]   in_payload = '0;
  logic [N-1:0]     out_valid;
  logic [N*W-1:0]   out_payload;
  logic [N-1:0]     dropped;
  logic             conflict;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sort_route_switch #(.N_PORTS(N), .PAYLOAD_W(W)) i_sort_route_switch (
    .clk, .rst, .in_valid, .in_dest, .in_payload,
    .out_valid, .out_payload, .dropped, .conflict
  );

  // Expected-value history, index 0 = slot just driven.
  logic [N-1:0]   hv;
  logic [N-1:0]   ev [3];
  logic [N*W-1:0] ep [3];
  logic [N-1:0]   ed [3];

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Lowest-index winner per destination, losers flagged (R4, R5).
  task automatic model(input logic [N-1:0] v, input logic [N*A-1:0] d, input logic [N*W-1:0] p,
                       output logic [N-1:0] mv, output logic [N*W-1:0] mp, output logic [N-1:0] md);
    mv = '0; mp = '0; md = '0;
    for (int i = 0; i < N; i++) begin
      if (v[i]) begin
        if (mv[d[i*A +: A]]) md[i] = 1'b1;
        else begin
          mv[d[i*A +: A]] = 1'b1;
          mp[d[i*A +: A]*W +: W] = p[i*W +: W];
        end
      end
    end
  endtask

  // One slot per cycle; outputs checked for the slot driven two cycles earlier (R2).
  task automatic step(input logic [N-1:0] v, input logic [N*A-1:0] d, input logic [N*W-1:0] p);
    @(negedge clk);
    hv[2] = hv[1]; ev[2] = ev[1]; ep[2] = ep[1]; ed[2] = ed[1];
    hv[1] = hv[0]; ev[1] = ev[0]; ep[1] = ep[0]; ed[1] = ed[0];
    if (hv[2]) begin
      check(out_valid == ev[2], "R3", "out_valid", 64'(out_valid), 64'(ev[2]));
      check(out_payload == ep[2], "R4", "out_payload", 64'(out_payload), 64'(ep[2]));
      check(dropped == ed[2], "R5", "dropped", 64'(dropped), 64'(ed[2]));
      check(conflict == 1'b0, "R7", "conflict", 64'(conflict), 64'd0);
    end
    model(v, d, p, ev[0], ep[0], ed[0]);
    hv[0] = 1'b1;
    in_valid = v; in_dest = d; in_payload = p;
  endtask

  function automatic logic [N*A-1:0] pack_dest(input int unsigned s0, s1, s2, s3, s4, s5, s6, s7);
    return {A'(s7), A'(s6), A'(s5), A'(s4), A'(s3), A'(s2), A'(s1), A'(s0)};
  endfunction

  initial begin
    logic [N*W-1:0] pay;
    hv = '0;
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: quiet outputs under reset.
    check(out_valid == '0 && dropped == '0 && !conflict && out_payload == '0,
          "R1", "reset outputs", {out_valid, dropped, 47'(conflict)}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == '0 && dropped == '0 && !conflict, "R1", "first cycle after reset",
          {out_valid, dropped, 47'(conflict)}, 64'd0);

    for (int i = 0; i < N; i++) pay[i*W +: W] = W'(8'h10 + i);
    // R3 R8: empty slot, identity permutation, reversed permutation.
    step('0, '0, '0);
    step('1, pack_dest(0,1,2,3,4,5,6,7), pay);
    step('1, pack_dest(7,6,5,4,3,2,1,0), pay);
    // R3 R5: gaps plus duplicates: lanes 1,2 -> 2, lane 4 -> 3.
    step(8'b0001_0110, pack_dest(5,2,2,7,3,1,0,6), pay);
    // R4 R5: every lane to port 5, lane 0 must win.
    step('1, pack_dest(5,5,5,5,5,5,5,5), pay);
    // R4: only the top lanes collide, lane 6 beats lane 7.
    step(8'b1100_0000, pack_dest(0,0,0,0,0,0,1,1), pay);
    // R6: invalid lanes carry garbage aimed at the one valid lane's port.
    step(8'b0000_1000, pack_dest(4,4,4,4,4,4,4,4), {N{8'hFF}} ^ pay);
    step(8'b0000_1000, pack_dest(4,4,4,4,4,4,4,4), pay);

    // Random slots with mixed density and frequent repeats (R2..R7).
    for (int t = 0; t < 600; t++) begin
      logic [N-1:0]   v;
      logic [N*A-1:0] d;
      logic [N*W-1:0] p;
      int unsigned dens;
      dens = $urandom_range(0, 4);
      for (int i = 0; i < N; i++) begin
        v[i] = ($urandom_range(0, 3) < dens);
        d[i*A +: A] = (t % 3 == 0) ? A'($urandom_range(0, 2)) : A'($urandom);
        p[i*W +: W] = W'($urandom);
      end
      step(v, d, p);
    end
    step('0, '0, '0);
    step('0, '0, '0);
    step('0, '0, '0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule